// File: doc/BRIEF.md
# Clear-on-Read Interrupt Flag Register

This block keeps one sticky flag for each of three interrupt sources (periodic tick, alarm match, update finished). It drives an active-low interrupt request line. The timekeeping logic supplies single-cycle event pulses. A control register supplies one enable bit per source. The host reads the flags through an 8-bit byte. Bit 7 of that byte summarises whether the request line is asserted.

A read is marked by `rd_cyc`, which stays high for the whole read. When the read begins, the byte is captured, and it stays frozen until `rd_cyc` drops. On the first cycle with `rd_cyc` low, every flag is cleared, so the host consumes exactly what it saw. An event that arrives while the read is in progress goes into a per-source pending bit. That bit is posted into the flags on the cycle the read ends, so no event is lost between the captured value and the clear.

The read tracker is a two-state machine. `ST_IDLE` means no read is active. The flags follow events, and the byte shows live state. `ST_READ` means a read is active. The byte shows the captured value, and events go to the pending bits. There are two transitions. START (`ST_IDLE` to `ST_READ`) is taken when `rd_cyc` is high. FINISH (`ST_READ` to `ST_IDLE`) is taken when `rd_cyc` is low, and it clears the flags and posts the pending bits.

Top module: `irq_flag_reg`

## Requirements
- R1: Each flag is set on the clock edge that samples its event pulse high, whatever its enable bit. The flag positions are periodic at bit 6, alarm at bit 5 and update-ended at bit 4.
- R2: Bits 3 to 0 of `flag_byte` always read 0.
- R3: `irq_n` is low exactly while some source has both its flag and its enable set. Setting an enable while its flag is pending drives `irq_n` low in the same cycle, with no clock edge needed.
- R4: Outside a read, bit 7 of `flag_byte` equals the inverse of `irq_n`.
- R5: On the first edge that sees `rd_cyc` high, the byte is captured. The capture includes any event pulse sampled on that same edge. The byte then stays unchanged for as long as `rd_cyc` stays high.
- R6: On the first edge that sees `rd_cyc` low after a read, all flags and bit 7 are cleared. If no event was held, `irq_n` is high from that edge on.
- R7: Events sampled during a read, including on the edge that ends it, are not lost. They appear in the flags right after the read ends.
- R8: While `rst_n` is low, all flags and pending events are cleared, `flag_byte` reads 0, `irq_n` is high and the tracker returns to `ST_IDLE`.
- R9: The tracker goes from `ST_IDLE` to `ST_READ` when `rd_cyc` is high, and back when it is low. Once back in `ST_IDLE`, the byte again shows live flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears flags |
| ev_per | input | 1 | Periodic event pulse |
| ev_alm | input | 1 | Alarm event pulse |
| ev_upd | input | 1 | Update-ended event pulse |
| en_per | input | 1 | Periodic interrupt enable |
| en_alm | input | 1 | Alarm interrupt enable |
| en_upd | input | 1 | Update-ended interrupt enable |
| rd_cyc | input | 1 | High for the duration of a flag-byte read |
| flag_byte | output | 8 | Summary bit 7, flags at bits 6..4, zeros below |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench fires an event in the middle of a read, on the cycle a read starts and on the cycle a read ends. A design that cleared on read without a pending store would drop the middle event. One that sampled too late would clear the start-cycle event without ever showing it. One that cleared after posting would drop the end-cycle event. The bench also enables a source whose flag is already set. A design that registered the request line, or that gated flag setting on the enable, would show a late `irq_n` or an empty flag byte. Finally, it asserts reset while flags are set, and checks that the captured byte stays frozen over a long read while the live state underneath it changes.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
    localparam int NSRC     = 3;
    localparam int BYTE_W   = 8;
    localparam int FLAG_LSB = 4;
    localparam int SUM_BIT  = BYTE_W - 1;
    localparam int IDX_UPD  = 0;
    localparam int IDX_ALM  = 1;
    localparam int IDX_PER  = 2;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_READ = 1'b1
    } rd_state_t;
endpackage

// File: rtl/irqf_rd_ctrl.sv
module irqf_rd_ctrl
    import irqf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_cyc,
    output logic rd_start,
    output logic rd_end,
    output logic in_read
);
    rd_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_cyc)  state_d = ST_READ;
            ST_READ: if (!rd_cyc) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        rd_start = 1'b0;
        rd_end   = 1'b0;
        in_read  = 1'b0;
        unique case (state_q)
            ST_IDLE: rd_start = rd_cyc;
            ST_READ: begin
                in_read = 1'b1;
                rd_end  = !rd_cyc;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irqf_flag_cell.sv
module irqf_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic ev,
    input  logic in_read,
    input  logic rd_end,
    output logic flag,
    output logic flag_nxt,
    output logic pend
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
            pend <= 1'b0;
        end else if (rd_end) begin
            flag <= pend | ev;
            pend <= 1'b0;
        end else if (in_read) begin
            pend <= pend | ev;
        end else begin
            flag <= flag | ev;
        end
    end

    assign flag_nxt = flag | ev;
endmodule

// File: rtl/irqf_snapshot.sv
module irqf_snapshot
    import irqf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_start,
    input  logic              in_read,
    input  logic [NSRC-1:0]   flag_now,
    input  logic [NSRC-1:0]   flag_nxt,
    input  logic [NSRC-1:0]   en_vec,
    output logic [BYTE_W-1:0] byte_out
);
    localparam int PAD_W = FLAG_LSB;

    logic [BYTE_W-1:0] snap_q;
    logic [BYTE_W-1:0] live_byte;
    logic [BYTE_W-1:0] start_byte;

    assign live_byte  = {|(flag_now & en_vec), flag_now, {PAD_W{1'b0}}};
    assign start_byte = {|(flag_nxt & en_vec), flag_nxt, {PAD_W{1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        snap_q <= '0;
        else if (rd_start) snap_q <= start_byte;
    end

    assign byte_out = in_read ? snap_q : live_byte;
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
    import irqf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_per,
    input  logic       ev_alm,
    input  logic       ev_upd,
    input  logic       en_per,
    input  logic       en_alm,
    input  logic       en_upd,
    input  logic       rd_cyc,
    output logic [7:0] flag_byte,
    output logic       irq_n
);
    logic [NSRC-1:0] ev_vec, en_vec, flag_vec, nxt_vec, pend_vec;
    logic            rd_start, rd_end, in_read;

    always_comb begin
        ev_vec          = '0;
        en_vec          = '0;
        ev_vec[IDX_UPD] = ev_upd;
        ev_vec[IDX_ALM] = ev_alm;
        ev_vec[IDX_PER] = ev_per;
        en_vec[IDX_UPD] = en_upd;
        en_vec[IDX_ALM] = en_alm;
        en_vec[IDX_PER] = en_per;
    end

    irqf_rd_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_cyc   (rd_cyc),
        .rd_start (rd_start),
        .rd_end   (rd_end),
        .in_read  (in_read)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_cell
        irqf_flag_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev       (ev_vec[i]),
            .in_read  (in_read),
            .rd_end   (rd_end),
            .flag     (flag_vec[i]),
            .flag_nxt (nxt_vec[i]),
            .pend     (pend_vec[i])
        );
    end

    irqf_snapshot u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_start (rd_start),
        .in_read  (in_read),
        .flag_now (flag_vec),
        .flag_nxt (nxt_vec),
        .en_vec   (en_vec),
        .byte_out (flag_byte)
    );

    assign irq_n = ~|(flag_vec & en_vec);
endmodule

// File: rtl/irqf_checker.sv
module irqf_checker
    import irqf_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            rd_cyc,
    input logic            in_read,
    input logic [NSRC-1:0] ev_vec,
    input logic [NSRC-1:0] en_vec,
    input logic [NSRC-1:0] pend_vec,
    input logic [7:0]      flag_byte,
    input logic            irq_n
);
    p_poll_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_read && !rd_cyc && ev_vec[IDX_PER]) |=> flag_byte[6]);

    p_irq_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_read && !irq_n) |-> (|(flag_byte[6:4] & en_vec)));

    p_summary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_read |-> (irq_n == !flag_byte[7]));

    p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_read && $past(in_read)) |-> $stable(flag_byte));

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_read && !rd_cyc && !(|ev_vec) && !(|pend_vec)) |=> (flag_byte == 8'h00 && irq_n));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_read && rd_cyc && ev_vec[IDX_ALM]) |=> pend_vec[IDX_ALM]);

    p_enter_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_read && rd_cyc) |=> in_read);
endmodule

bind irq_flag_reg irqf_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_cyc    (rd_cyc),
    .in_read   (in_read),
    .ev_vec    (ev_vec),
    .en_vec    (en_vec),
    .pend_vec  (pend_vec),
    .flag_byte (flag_byte),
    .irq_n     (irq_n)
);

// File: tb/irq_flag_reg_tb.sv
`timescale 1ns/1ps
module irq_flag_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_per = 0, ev_alm = 0, ev_upd = 0;
    logic       en_per = 0, en_alm = 0, en_upd = 0;
    logic       rd_cyc = 0;
    logic [7:0] flag_byte;
    logic       irq_n;
    int         total = 0;
    int         bad = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    irq_flag_reg u_dut (
        .clk(clk), .rst_n(rst_n),
        .ev_per(ev_per), .ev_alm(ev_alm), .ev_upd(ev_upd),
        .en_per(en_per), .en_alm(en_alm), .en_upd(en_upd),
        .rd_cyc(rd_cyc), .flag_byte(flag_byte), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); #1; endtask

    task automatic t_reset();
        chk("R8 reset byte", {1'b0, flag_byte}, 9'h000);
        chk("R8 reset irq", {8'h0, irq_n}, 9'h001);
    endtask

    task automatic t_poll();
        @(negedge clk); ev_per = 1;
        @(negedge clk); ev_per = 0; ev_alm = 1;
        @(negedge clk); ev_alm = 0; ev_upd = 1;
        @(negedge clk); ev_upd = 0; #1;
        chk("R1 poll flags", {1'b0, flag_byte}, 9'h070);
        chk("R2 low bits zero", {5'h0, flag_byte[3:0]}, 9'h000);
        chk("R3 no irq when disabled", {8'h0, irq_n}, 9'h001);
    endtask

    task automatic t_enable_pending();
        @(negedge clk); en_alm = 1; #1;
        chk("R3 enable pending immediate", {8'h0, irq_n}, 9'h000);
        chk("R4 summary bit", {1'b0, flag_byte}, 9'h0F0);
    endtask

    task automatic t_read_mid_event();
        @(negedge clk); rd_cyc = 1;
        tick();
        chk("R5 captured byte", {1'b0, flag_byte}, 9'h0F0);
        @(negedge clk); ev_per = 1;
        @(negedge clk); ev_per = 0; #1;
        chk("R5 stable during read", {1'b0, flag_byte}, 9'h0F0);
        chk("R7 irq unchanged during read", {8'h0, irq_n}, 9'h000);
        @(negedge clk); rd_cyc = 0;
        tick();
        chk("R7 held event posted", {1'b0, flag_byte}, 9'h040);
        chk("R6 irq released", {8'h0, irq_n}, 9'h001);
    endtask

    task automatic t_clear_all();
        @(negedge clk); rd_cyc = 1;
        tick();
        chk("R5 capture periodic", {1'b0, flag_byte}, 9'h040);
        @(negedge clk); rd_cyc = 0;
        tick();
        chk("R6 all cleared", {1'b0, flag_byte}, 9'h000);
    endtask

    task automatic t_end_event();
        @(negedge clk); rd_cyc = 1;
        @(negedge clk); rd_cyc = 0; ev_upd = 1;
        @(negedge clk); ev_upd = 0; #1;
        chk("R7 end-cycle event kept", {1'b0, flag_byte}, 9'h010);
        @(negedge clk); rd_cyc = 1;
        @(negedge clk); rd_cyc = 0;
        tick();
        chk("R6 cleared after consume", {1'b0, flag_byte}, 9'h000);
    endtask

    task automatic t_start_event();
        @(negedge clk); rd_cyc = 1; ev_alm = 1;
        @(negedge clk); ev_alm = 0; #1;
        chk("R5 start-cycle event captured", {1'b0, flag_byte}, 9'h0A0);
        @(negedge clk); rd_cyc = 0;
        tick();
        chk("R6 start event consumed", {1'b0, flag_byte}, 9'h000);
        chk("R6 irq high", {8'h0, irq_n}, 9'h001);
    endtask

    task automatic t_long_read();
        @(negedge clk); rd_cyc = 1;
        tick();
        en_upd = 1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); ev_upd = (i == 3);
        end
        ev_upd = 0; #1;
        chk("R9 still frozen in read", {1'b0, flag_byte}, 9'h000);
        @(negedge clk); rd_cyc = 0;
        tick();
        chk("R9 live after read", {1'b0, flag_byte}, 9'h090);
        @(negedge clk); ev_per = 1;
        @(negedge clk); ev_per = 0; #1;
        chk("R9 live tracks event", {1'b0, flag_byte}, 9'h0D0);
    endtask

    task automatic t_reset_mid();
        @(negedge clk); rst_n = 0; #1;
        chk("R8 reset clears flags", {1'b0, flag_byte}, 9'h000);
        chk("R8 reset irq high", {8'h0, irq_n}, 9'h001);
        @(negedge clk); rst_n = 1;
        @(negedge clk); ev_alm = 1;
        @(negedge clk); ev_alm = 0; #1;
        chk("R1 set after reset", {1'b0, flag_byte}, 9'h0A0);
    endtask

    initial begin
        #1 chk("R8 reset byte t0", {1'b0, flag_byte}, 9'h000);
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_poll();
        t_enable_pending();
        t_read_mid_event();
        t_clear_all();
        t_end_event();
        t_start_event();
        t_long_read();
        t_reset_mid();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule